// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the transmit and receive error counts of a CAN controller and derives from them the node's fault confinement state: error-active, error-passive or bus-off. The protocol engine feeds it single-cycle event strobes: transmit error, receive error, transmit success, receive success, and one pulse for each run of eleven consecutive recessive bits seen on the bus. Every event is registered on the next rising clock edge. Both counts and the three state flags are available as outputs.

While the node is bus-off, the receive counter is reused as the recovery progress count. Each recessive-run pulse advances it. When it reaches the recovery threshold, the node returns to error-active with both counts cleared.

Software sees both counts in one 16-bit read word. In a dedicated test mode, and only while the controller is halted, software can write one value into both counters at once.

Top module: `can_errcnt_top`

## Requirements
- R1: After reset (`rst_n` low), both counts are 0 and `err_active` is 1. `rd_data` always shows the transmit count in bits 15:8 and the receive count in bits 7:0, and matches `tx_count` and `rx_count`.
- R2: A `reset_req` pulse clears both counts and leaves bus-off at the next edge. It takes priority over every event and write in the same cycle.
- R3: A write (`wr_en` high) is accepted only when `test_sel` equals 3'b100 and `halted` is 1. Any other write leaves both counts and the flags unchanged.
- R4: An accepted write loads `wr_data[15:8]` into both the transmit and the receive counter, and `wr_data[7:0]` is discarded. The write overrides any protocol events in the same cycle.
- R5: Outside bus-off, a transmit error adds 8 to the transmit count. A transmit success subtracts 1, stopping at 0. If both strobes occur in the same cycle, the error wins.
- R6: Outside bus-off, a receive error adds 1 to the receive count, saturating at 255. A receive success subtracts 1, stopping at 0. If both occur together, the error wins. Recessive-run pulses have no effect outside bus-off.
- R7: Outside bus-off, `err_passive` is 1 exactly when either count is at least 128, and `err_active` is 1 exactly when both counts are below 128. At every moment exactly one of `err_active`, `err_passive` and `bus_off` is 1.
- R8: Outside bus-off, a transmit error that would take the transmit count above 255 sets `bus_off` and clears both counts at the same edge.
- R9: While in bus-off, each recessive-run pulse adds 1 to the receive count. Transmit and receive error and success strobes have no effect.
- R10: In bus-off, the recessive-run pulse that brings the receive count to 128 clears `bus_off`, clears both counts and restores `err_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Controller reset request, clears counters |
| ev_tx_err | input | 1 | Transmit error strobe |
| ev_rx_err | input | 1 | Receive error strobe |
| ev_tx_ok | input | 1 | Successful transmit strobe |
| ev_rx_ok | input | 1 | Successful receive strobe |
| ev_idle_run | input | 1 | One pulse per run of 11 recessive bits |
| test_sel | input | 3 | Test mode field |
| halted | input | 1 | Controller is in halt mode |
| wr_en | input | 1 | Software write strobe for the counter word |
| wr_data | input | 16 | Software write data |
| rd_data | output | 16 | Counter word: transmit count in 15:8, receive count in 7:0 |
| tx_count | output | 8 | Transmit error count |
| rx_count | output | 8 | Receive error count |
| err_active | output | 1 | Node is error-active |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |

## Verification
The hardest state to reach is the bus-off recovery boundary. Getting there takes about 32 net transmit errors, followed by 128 recessive-run pulses, and any reset request along the way resets the walk. The directed part takes the shortest route: a test write of 250 followed by one transmit error enters bus-off. It then steps the run count through 127 to 128 while error and success strobes are applied and ignored. The random part biases transmit errors above transmit successes and issues recessive-run pulses on about half the cycles. This makes bus-off entry and exit recur many times across the run.

// File: rtl/can_errcnt_pkg.sv
package can_errcnt_pkg;

    // Operation selected for the transmit counter in one cycle
    typedef enum logic [1:0] {
        TXOP_HOLD = 2'd0,
        TXOP_ADD  = 2'd1,
        TXOP_SUB  = 2'd2
    } tx_op_e;

    // Operation selected for the receive counter in one cycle
    typedef enum logic [1:0] {
        RXOP_HOLD = 2'd0,
        RXOP_ADD  = 2'd1,
        RXOP_SUB  = 2'd2,
        RXOP_RUN  = 2'd3
    } rx_op_e;

endpackage

// File: rtl/can_fc_wrport.sv
module can_fc_wrport #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned TEST_W    = 3,
    parameter logic [2:0]  TEST_CODE = 3'b100,
    localparam int unsigned WORD_W   = 2 * CNT_W
) (
    input  logic [TEST_W-1:0] test_sel,
    input  logic              halted,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [CNT_W-1:0]  rx_cnt,
    output logic              wr_accept,
    output logic [CNT_W-1:0]  wr_value,
    output logic [WORD_W-1:0] rd_word
);
    logic test_match;

    always_comb begin
        test_match = (test_sel == TEST_W'(TEST_CODE));
        wr_accept  = wr_en && test_match && halted;
        // upper field carries the value for both counters
        wr_value   = wr_data[WORD_W-1:CNT_W];
        rd_word    = {tx_cnt, rx_cnt};
    end
endmodule

// File: rtl/can_fc_txnext.sv
module can_fc_txnext
    import can_errcnt_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned TX_ERR_STEP = 8,
    localparam int unsigned SUM_W      = CNT_W + 1
) (
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic             tx_err,
    input  logic             tx_ok,
    output logic [CNT_W-1:0] tx_nxt,
    output logic             tx_over
);
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

    tx_op_e           op;
    logic [SUM_W-1:0] sum;

    always_comb begin
        if (tx_err)     op = TXOP_ADD;
        else if (tx_ok) op = TXOP_SUB;
        else            op = TXOP_HOLD;

        sum     = {1'b0, tx_cnt} + SUM_W'(TX_ERR_STEP);
        tx_over = (op == TXOP_ADD) && (sum > CNT_MAX);

        unique case (op)
            TXOP_ADD: tx_nxt = tx_over ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
            TXOP_SUB: tx_nxt = (tx_cnt == '0) ? '0 : tx_cnt - CNT_W'(1);
            default:  tx_nxt = tx_cnt;
        endcase
    end
endmodule

// File: rtl/can_fc_rxnext.sv
module can_fc_rxnext
    import can_errcnt_pkg::*;
#(
    parameter int unsigned CNT_W        = 8,
    parameter int unsigned RECOVER_RUNS = 128,
    localparam int unsigned SUM_W       = CNT_W + 1
) (
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             bus_off,
    input  logic             rx_err,
    input  logic             rx_ok,
    input  logic             idle_run,
    output logic [CNT_W-1:0] rx_nxt,
    output logic             recovered
);
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

    rx_op_e           op;
    logic [SUM_W-1:0] inc;

    always_comb begin
        if (bus_off)     op = idle_run ? RXOP_RUN : RXOP_HOLD;
        else if (rx_err) op = RXOP_ADD;
        else if (rx_ok)  op = RXOP_SUB;
        else             op = RXOP_HOLD;

        inc       = {1'b0, rx_cnt} + SUM_W'(1);
        recovered = (op == RXOP_RUN) && (inc >= SUM_W'(RECOVER_RUNS));

        unique case (op)
            RXOP_ADD: rx_nxt = (inc > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : inc[CNT_W-1:0];
            RXOP_SUB: rx_nxt = (rx_cnt == '0) ? '0 : rx_cnt - CNT_W'(1);
            RXOP_RUN: rx_nxt = recovered ? '0 : inc[CNT_W-1:0];
            default:  rx_nxt = rx_cnt;
        endcase
    end
endmodule

// File: rtl/can_fc_status.sv
module can_fc_status #(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned PASSIVE_LVL = 128
) (
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             bus_off_q,
    output logic             err_active,
    output logic             err_passive
);
    logic over_lvl;

    always_comb begin
        over_lvl    = (tx_cnt >= CNT_W'(PASSIVE_LVL)) || (rx_cnt >= CNT_W'(PASSIVE_LVL));
        err_passive = !bus_off_q && over_lvl;
        err_active  = !bus_off_q && !over_lvl;
    end
endmodule

// File: rtl/can_errcnt_top.sv
module can_errcnt_top #(
    parameter int unsigned CNT_W        = 8,
    parameter int unsigned TEST_W       = 3,
    parameter logic [2:0]  TEST_CODE    = 3'b100,
    parameter int unsigned TX_ERR_STEP  = 8,
    parameter int unsigned PASSIVE_LVL  = 128,
    parameter int unsigned RECOVER_RUNS = 128,
    localparam int unsigned WORD_W      = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              ev_tx_err,
    input  logic              ev_rx_err,
    input  logic              ev_tx_ok,
    input  logic              ev_rx_ok,
    input  logic              ev_idle_run,
    input  logic [TEST_W-1:0] test_sel,
    input  logic              halted,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic              err_active,
    output logic              err_passive,
    output logic              bus_off
);
    typedef struct packed {
        logic [CNT_W-1:0] tx;
        logic [CNT_W-1:0] rx;
        logic             boff;
    } fc_state_t;

    fc_state_t st_d, st_q;

    logic             wr_accept;
    logic [CNT_W-1:0] wr_value;
    logic [CNT_W-1:0] tx_nxt;
    logic             tx_over;
    logic [CNT_W-1:0] rx_nxt;
    logic             recovered;

    can_fc_wrport #(
        .CNT_W     (CNT_W),
        .TEST_W    (TEST_W),
        .TEST_CODE (TEST_CODE)
    ) u_wrport (
        .test_sel  (test_sel),
        .halted    (halted),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_cnt    (st_q.tx),
        .rx_cnt    (st_q.rx),
        .wr_accept (wr_accept),
        .wr_value  (wr_value),
        .rd_word   (rd_data)
    );

    can_fc_txnext #(
        .CNT_W       (CNT_W),
        .TX_ERR_STEP (TX_ERR_STEP)
    ) u_txnext (
        .tx_cnt  (st_q.tx),
        .tx_err  (ev_tx_err),
        .tx_ok   (ev_tx_ok),
        .tx_nxt  (tx_nxt),
        .tx_over (tx_over)
    );

    can_fc_rxnext #(
        .CNT_W        (CNT_W),
        .RECOVER_RUNS (RECOVER_RUNS)
    ) u_rxnext (
        .rx_cnt    (st_q.rx),
        .bus_off   (st_q.boff),
        .rx_err    (ev_rx_err),
        .rx_ok     (ev_rx_ok),
        .idle_run  (ev_idle_run),
        .rx_nxt    (rx_nxt),
        .recovered (recovered)
    );

    can_fc_status #(
        .CNT_W       (CNT_W),
        .PASSIVE_LVL (PASSIVE_LVL)
    ) u_status (
        .tx_cnt      (st_q.tx),
        .rx_cnt      (st_q.rx),
        .bus_off_q   (st_q.boff),
        .err_active  (err_active),
        .err_passive (err_passive)
    );

    // Next-state selection, highest priority first
    always_comb begin
        st_d = st_q;
        if (reset_req) begin
            st_d = '0;
        end else if (wr_accept) begin
            st_d.tx = wr_value;
            st_d.rx = wr_value;
        end else if (st_q.boff) begin
            st_d.rx = rx_nxt;
            if (recovered) begin
                st_d = '0;
            end
        end else if (tx_over) begin
            st_d      = '0;
            st_d.boff = 1'b1;
        end else begin
            st_d.tx = tx_nxt;
            st_d.rx = rx_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        tx_count = st_q.tx;
        rx_count = st_q.rx;
        bus_off  = st_q.boff;
    end
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker #(
    parameter int unsigned CNT_W        = 8,
    parameter int unsigned TEST_W       = 3,
    parameter logic [2:0]  TEST_CODE    = 3'b100,
    parameter int unsigned TX_ERR_STEP  = 8,
    parameter int unsigned RECOVER_RUNS = 128,
    localparam int unsigned WORD_W      = 2 * CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reset_req,
    input logic              ev_tx_err,
    input logic              ev_rx_err,
    input logic              ev_tx_ok,
    input logic              ev_rx_ok,
    input logic              ev_idle_run,
    input logic [TEST_W-1:0] test_sel,
    input logic              halted,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic              err_active,
    input logic              err_passive,
    input logic              bus_off
);
    logic wr_ok;
    logic any_ev;
    assign wr_ok  = wr_en && (test_sel == TEST_W'(TEST_CODE)) && halted;
    assign any_ev = ev_tx_err || ev_rx_err || ev_tx_ok || ev_rx_ok || ev_idle_run;

    assert_reset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (tx_count == '0 && rx_count == '0 && !bus_off));

    assert_word_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == {tx_count, rx_count});

    assert_bad_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok && !any_ev && !reset_req) |=>
        ($stable(tx_count) && $stable(rx_count) && $stable(bus_off)));

    assert_write_loads_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !reset_req) |=>
        (tx_count == $past(wr_data[WORD_W-1:CNT_W]) && rx_count == $past(wr_data[WORD_W-1:CNT_W])));

    assert_tx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_off && ev_tx_err && !reset_req && !wr_ok &&
         ({1'b0, tx_count} + (CNT_W+1)'(TX_ERR_STEP) <= (CNT_W+1)'((1 << CNT_W) - 1))) |=>
        (tx_count == $past(tx_count) + CNT_W'(TX_ERR_STEP)));

    assert_one_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({err_active, err_passive, bus_off}) == 1);

    assert_enter_busoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_off && ev_tx_err && !reset_req && !wr_ok &&
         ({1'b0, tx_count} + (CNT_W+1)'(TX_ERR_STEP) > (CNT_W+1)'((1 << CNT_W) - 1))) |=>
        (bus_off && tx_count == '0 && rx_count == '0));

    assert_busoff_holds_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !reset_req && !wr_ok && !ev_idle_run) |=>
        ($stable(tx_count) && $stable(rx_count) && bus_off));

    assert_recover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && ev_idle_run && !reset_req && !wr_ok &&
         rx_count == CNT_W'(RECOVER_RUNS - 1)) |=>
        (!bus_off && err_active && tx_count == '0 && rx_count == '0));
endmodule

bind can_errcnt_top can_fc_checker #(
    .CNT_W        (CNT_W),
    .TEST_W       (TEST_W),
    .TEST_CODE    (TEST_CODE),
    .TX_ERR_STEP  (TX_ERR_STEP),
    .RECOVER_RUNS (RECOVER_RUNS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_req   (reset_req),
    .ev_tx_err   (ev_tx_err),
    .ev_rx_err   (ev_rx_err),
    .ev_tx_ok    (ev_tx_ok),
    .ev_rx_ok    (ev_rx_ok),
    .ev_idle_run (ev_idle_run),
    .test_sel    (test_sel),
    .halted      (halted),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .tx_count    (tx_count),
    .rx_count    (rx_count),
    .err_active  (err_active),
    .err_passive (err_passive),
    .bus_off     (bus_off)
);

// File: tb/can_errcnt_top_tb.sv
`timescale 1ns/1ps
module can_errcnt_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_req = 1'b0;
    logic        ev_tx_err = 1'b0, ev_rx_err = 1'b0, ev_tx_ok = 1'b0, ev_rx_ok = 1'b0;
    logic        ev_idle_run = 1'b0;
    logic [2:0]  test_sel = 3'b000;
    logic        halted = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic [7:0]  tx_count, rx_count;
    logic        err_active, err_passive, bus_off;

    int n_cmp = 0;
    int n_bad = 0;
    int m_tx = 0, m_rx = 0;
    bit m_bo = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    can_errcnt_top u_dut (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req),
        .ev_tx_err(ev_tx_err), .ev_rx_err(ev_rx_err), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .ev_idle_run(ev_idle_run), .test_sel(test_sel), .halted(halted),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tx_count(tx_count), .rx_count(rx_count),
        .err_active(err_active), .err_passive(err_passive), .bus_off(bus_off)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model of the requirements, applied to the inputs present before an edge
    task automatic model_step();
        bit acc;
        acc = wr_en && (test_sel == 3'b100) && halted;
        if (reset_req) begin
            m_tx = 0; m_rx = 0; m_bo = 0;
        end else if (acc) begin
            m_tx = wr_data[15:8]; m_rx = wr_data[15:8];
        end else if (m_bo) begin
            if (ev_idle_run) begin
                m_rx = m_rx + 1;
                if (m_rx >= 128) begin m_tx = 0; m_rx = 0; m_bo = 0; end
            end
        end else if (ev_tx_err && m_tx + 8 > 255) begin
            m_tx = 0; m_rx = 0; m_bo = 1;
        end else begin
            if (ev_tx_err)                m_tx = m_tx + 8;
            else if (ev_tx_ok && m_tx > 0) m_tx = m_tx - 1;
            if (ev_rx_err)                m_rx = (m_rx < 255) ? m_rx + 1 : 255;
            else if (ev_rx_ok && m_rx > 0) m_rx = m_rx - 1;
        end
    endtask

    function automatic logic [2:0] exp_flags();
        if (m_bo) return 3'b001;
        if (m_tx >= 128 || m_rx >= 128) return 3'b010;
        return 3'b100;
    endfunction

    task automatic compare(input string tag);
        check({tag, " word"}, {16'h0, rd_data}, {16'h0, m_tx[7:0], m_rx[7:0]});
        check({tag, " state"}, {13'h0, tx_count, rx_count, err_active, err_passive, bus_off},
              {13'h0, m_tx[7:0], m_rx[7:0], exp_flags()});
    endtask

    task automatic clear_inputs();
        reset_req = 0; ev_tx_err = 0; ev_rx_err = 0; ev_tx_ok = 0; ev_rx_ok = 0;
        ev_idle_run = 0; wr_en = 0; test_sel = 3'b000; halted = 0; wr_data = 16'h0;
    endtask

    // Inputs are set at a falling edge; results are compared at the next falling edge
    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        clear_inputs();
    endtask

    task automatic do_write(input string tag, input logic [2:0] ts, input logic hl, input logic [15:0] d);
        wr_en = 1; test_sel = ts; halted = hl; wr_data = d;
        tick(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset hold");
        rst_n = 1;
        @(negedge clk);
        compare("R1 after reset");

        // R5: transmit errors climb by 8, reach passive at 128
        for (int i = 0; i < 16; i++) begin ev_tx_err = 1; tick("R5 tx error"); end
        check("R7 passive at tx 128", {29'h0, err_active, err_passive, bus_off}, 32'b010);
        ev_tx_ok = 1; tick("R7 back to active");
        check("R7 active at tx 127", {29'h0, err_active, err_passive, bus_off}, 32'b100);
        ev_tx_err = 1; ev_tx_ok = 1; tick("R5 error beats success");

        // R2: reset request wins over simultaneous events
        reset_req = 1; ev_tx_err = 1; ev_rx_err = 1; tick("R2 reset wins");
        check("R2 counts zero", {16'h0, rd_data}, 32'h0);
        ev_tx_ok = 1; ev_rx_ok = 1; tick("R5 floor at zero");
        ev_idle_run = 1; tick("R6 run pulse ignored outside bus-off");

        // R3: rejected writes
        do_write("R3 wrong test code", 3'b010, 1'b1, 16'h5A00);
        do_write("R3 not halted", 3'b100, 1'b0, 16'h5A00);
        check("R3 counts untouched", {16'h0, rd_data}, 32'h0);

        // R4: accepted write, low byte discarded, events overridden
        ev_tx_err = 1; ev_rx_err = 1;
        do_write("R4 write loads both", 3'b100, 1'b1, 16'hFA33);
        check("R4 both 250", {16'h0, rd_data}, 32'hFAFA);

        // R6: receive saturation
        for (int i = 0; i < 7; i++) begin ev_rx_err = 1; tick("R6 rx saturate"); end
        check("R6 rx at 255", {24'h0, rx_count}, 32'd255);

        // R8: transmit overflow enters bus-off
        ev_tx_err = 1; ev_rx_err = 1; tick("R8 enter bus-off");
        check("R8 bus_off flag", {31'h0, bus_off}, 32'd1);

        // R9, R10: recovery walk with ignored strobes
        for (int i = 0; i < 127; i++) begin
            ev_idle_run = 1;
            ev_tx_err = (i % 3 == 0); ev_rx_err = (i % 5 == 0); ev_tx_ok = (i % 7 == 0);
            tick("R9 bus-off run count");
        end
        check("R9 rx at 127 still off", {23'h0, bus_off, rx_count}, {23'h0, 1'b1, 8'd127});
        ev_tx_err = 1; ev_rx_ok = 1; tick("R9 strobes ignored");
        ev_idle_run = 1; tick("R10 recovery");
        check("R10 active after recovery", {29'h0, err_active, err_passive, bus_off}, 32'b100);

        // Constrained random phase
        void'($urandom(32'd1357));
        for (int i = 0; i < 6000; i++) begin
            string tag;
            tag = m_bo ? "R9 random" : "R5 random";
            reset_req   = ($urandom % 600) == 0;
            ev_tx_err   = ($urandom % 3) == 0;
            ev_tx_ok    = ($urandom % 4) == 0;
            ev_rx_err   = ($urandom % 3) == 0;
            ev_rx_ok    = ($urandom % 4) == 0;
            ev_idle_run = ($urandom % 2) == 0;
            if (($urandom % 50) == 0) begin
                wr_en = 1;
                test_sel = (($urandom % 2) == 0) ? 3'b100 : 3'($urandom);
                halted = 1'($urandom);
                wr_data = 16'($urandom);
                tag = "R4 random write";
            end
            tick(tag);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule